// File: doc/BRIEF.md
# Prioritized Interrupt Level Selector

This block sits beside a processor core and decides which level interrupt, if any, the core should take next. It merges fifteen external level request lines with the level bits of a software-interrupt register. It folds the two timer-match bits of that register into level 14. It then selects the highest pending level that lies strictly above the core's current priority. The result is a registered request line and a trap-type code built from a fixed external-interrupt base ORed with the chosen level.

The selector is recomputed every clock and registered once, so the outputs follow the inputs by one cycle. Three conditions override the plain selection. A busy vector interrupt freezes both outputs, because vector interrupts outrank every level. A disabled global enable withdraws any request. A nested external-interrupt trap with a higher code is never preempted by a lower candidate.

Top module: `irq_level_sel`

## Requirements
- R1: The pending set is the OR of `ext_lvl[15:1]` and `sw_int[15:1]`. Bit 0 and bit 16 of `sw_int` never raise their own level.
- R2: When `sw_int[0]` (tick match) or `sw_int[16]` (system-tick match) is set, level 14 is pending.
- R3: While `vec_busy` is 1, `irq_req` and `irq_tt` keep their values at the next clock edge.
- R4: Only levels strictly above `cur_pri` are eligible. With none eligible, the next edge gives `irq_req`=0 and `irq_tt`=0. `cur_pri`=15 masks every level, and `cur_pri`=0 admits levels 1 to 15.
- R5: The highest eligible level L is chosen, and `irq_tt` becomes 0x40 | L with `irq_req`=1. If that code is already presented, the outputs hold.
- R6: If `trap_lvl` is nonzero, `act_tt[8:4]` equals 0x04 and `act_tt` is greater than the candidate code, the outputs hold.
- R7: With a level eligible but `glb_ie`=0, the next edge gives `irq_req`=0 and `irq_tt`=0.
- R8: Reset (`rst_n`=0) gives `irq_req`=0 and `irq_tt`=0. Every change appears one clock edge after the inputs that cause it. `irq_tt` is zero whenever `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lvl | input | 15 | External level requests, bit i is level i (1..15) |
| sw_int | input | 17 | Software-interrupt register: bit 0 tick match, bits 15:1 levels, bit 16 system-tick match |
| cur_pri | input | 4 | Current processor priority |
| glb_ie | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| act_tt | input | 9 | Trap type of the active trap |
| vec_busy | input | 1 | Vector interrupt pending, outranks all levels |
| irq_req | output | 1 | Interrupt request to the core |
| irq_tt | output | 9 | Selected trap type |

## Verification
The only internal state is the presented request and code, and both are ports. A wrong selection or a missed clear is therefore visible one edge after the inputs that cause it. A stale code that survives a `vec_busy` window appears as soon as the window closes and the next recomputation either changes the code or wrongly fails to change it. The reference model runs the same one-edge update and flags the first cycle of divergence. It covers priority masking at 0 and 15, timer folding and nested-trap blocking.

// File: rtl/irq_level_sel_pkg.sv
package irq_level_sel_pkg;
  // Outputs registered by the selector
  typedef struct packed {
    logic       req;
    logic [8:0] tt;
  } sel_state_t;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
  parameter int NLVL    = 15,
  parameter int TMR_LVL = 14
) (
  input  logic [NLVL:1]   ext_lvl,
  input  logic [NLVL+1:0] sw_int,
  output logic [NLVL:1]   pend
);
  logic tmr_hit;
  assign tmr_hit = sw_int[0] | sw_int[NLVL+1];

  for (genvar i = 1; i <= NLVL; i++) begin : g_bit
    if (i == TMR_LVL) begin : g_tmr
      assign pend[i] = ext_lvl[i] | sw_int[i] | tmr_hit;
    end else begin : g_plain
      assign pend[i] = ext_lvl[i] | sw_int[i];
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NLVL = 15,
  parameter int LW   = $clog2(NLVL + 1)
) (
  input  logic [NLVL:1] pend,
  input  logic [LW-1:0] pri,
  output logic          hit,
  output logic [LW-1:0] lvl
);
  always_comb begin
    hit = 1'b0;
    lvl = '0;
    for (int i = 1; i <= NLVL; i++) begin
      if (pend[i] && (i > int'(pri))) begin
        hit = 1'b1;
        lvl = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel #(
  parameter int         NLVL    = 15,
  parameter int         TMR_LVL = 14,
  parameter int         TTW     = 9,
  parameter logic [8:0] TT_BASE = 9'h040,
  parameter int         TLW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NLVL:1]        ext_lvl,
  input  logic [NLVL+1:0]      sw_int,
  input  logic [$clog2(NLVL+1)-1:0] cur_pri,
  input  logic                 glb_ie,
  input  logic [TLW-1:0]       trap_lvl,
  input  logic [TTW-1:0]       act_tt,
  input  logic                 vec_busy,
  output logic                 irq_req,
  output logic [TTW-1:0]       irq_tt
);
  import irq_level_sel_pkg::*;

  localparam int LW = $clog2(NLVL + 1);

  logic [NLVL:1] pend;
  logic          hit;
  logic [LW-1:0] lvl;
  logic [TTW-1:0] cand;
  logic          blk;
  logic          upd_en;
  sel_state_t    st_q, st_d;

  irq_pend_merge #(.NLVL(NLVL), .TMR_LVL(TMR_LVL)) u_merge (
    .ext_lvl (ext_lvl),
    .sw_int  (sw_int),
    .pend    (pend)
  );

  irq_prio_pick #(.NLVL(NLVL), .LW(LW)) u_pick (
    .pend (pend),
    .pri  (cur_pri),
    .hit  (hit),
    .lvl  (lvl)
  );

  assign cand = TT_BASE | TTW'(lvl);
  assign blk  = (trap_lvl != '0) &&
                (act_tt[TTW-1:LW] == TT_BASE[TTW-1:LW]) &&
                (act_tt > cand);
  assign upd_en = !vec_busy;

  // Next-state selection
  always_comb begin
    st_d = st_q;
    if (!hit || !glb_ie) begin
      st_d.req = 1'b0;
      st_d.tt  = '0;
    end else if (!blk && (cand != st_q.tt)) begin
      st_d.req = 1'b1;
      st_d.tt  = cand;
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (upd_en) begin
      st_q <= st_d;
    end
  end

  assign irq_req = st_q.req;
  assign irq_tt  = st_q.tt;

  // R3
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

  // R4
  none_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && !hit) |=> (!irq_req && irq_tt == '0));

  // R7
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && !glb_ie) |=> (!irq_req && irq_tt == '0));

  // R6
  nest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && hit && glb_ie && blk) |=> ($stable(irq_req) && $stable(irq_tt)));

  // R5
  tt_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_tt[TTW-1:LW] == TT_BASE[TTW-1:LW] && irq_tt[LW-1:0] != '0));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_tt == '0));
endmodule

// File: tb/tb_irq_level_sel.sv
`timescale 1ns/1ps
module tb_irq_level_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:1] ext_lvl;
  logic [16:0] sw_int;
  logic [3:0]  cur_pri;
  logic        glb_ie;
  logic [2:0]  trap_lvl;
  logic [8:0]  act_tt;
  logic        vec_busy;
  logic        irq_req;
  logic [8:0]  irq_tt;

  int n_chk = 0;
  int n_bad = 0;
  logic       m_req;
  logic [8:0] m_tt;

  always #2 clk = ~clk;

  irq_level_sel dut (
    .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .sw_int(sw_int),
    .cur_pri(cur_pri), .glb_ie(glb_ie), .trap_lvl(trap_lvl),
    .act_tt(act_tt), .vec_busy(vec_busy), .irq_req(irq_req), .irq_tt(irq_tt)
  );

  // Reference: next {req,tt} and the requirement that governs it
  function automatic logic [9:0] ref_next(output string tag);
    logic [15:0] p;
    int hi;
    logic [8:0] c;
    p = {ext_lvl | sw_int[15:1], 1'b0};
    if (sw_int[0] || sw_int[16]) p[14] = 1'b1;
    hi = 0;
    for (int i = 1; i <= 15; i++)
      if (p[i] && i > int'(cur_pri)) hi = i;
    c = 9'h040 | 9'(hi);
    if (vec_busy) begin tag = "R3"; return {m_req, m_tt}; end
    if (hi == 0) begin tag = "R4"; return 10'h0; end
    if (!glb_ie) begin tag = "R7"; return 10'h0; end
    if (trap_lvl != 0 && act_tt[8:4] == 5'h04 && act_tt > c) begin
      tag = "R6"; return {m_req, m_tt};
    end
    tag = "R5";
    if (c != m_tt) return {1'b1, c};
    return {m_req, m_tt};
  endfunction

  task automatic chk(string tag, logic er, logic [8:0] et);
    n_chk++;
    if (irq_req !== er || irq_tt !== et) begin
      n_bad++;
      $display("FAIL %s: req=%0b tt=%03h expected req=%0b tt=%03h",
               tag, irq_req, irq_tt, er, et);
    end
  endtask

  // Drive at negedge, check one edge later against the model
  task automatic apply(logic [15:1] e, logic [16:0] s, logic [3:0] p,
                       logic ie, logic [2:0] t, logic [8:0] a, logic v);
    string tag;
    logic [9:0] nx;
    ext_lvl = e; sw_int = s; cur_pri = p; glb_ie = ie;
    trap_lvl = t; act_tt = a; vec_busy = v;
    nx = ref_next(tag);
    @(negedge clk);
    chk(tag, nx[9], nx[8:0]);
    m_req = nx[9]; m_tt = nx[8:0];
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: req=%0b tt=%03h expected completion", irq_req, irq_tt);
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ext_lvl = '0; sw_int = '0; cur_pri = '0; glb_ie = 1'b0;
    trap_lvl = '0; act_tt = '0; vec_busy = 1'b0;
    m_req = 1'b0; m_tt = '0;
    repeat (3) @(negedge clk);
    chk("R8", 1'b0, 9'h000);
    rst_n = 1'b1;

    // R4/R5: priority 0 admits every level
    for (int i = 1; i <= 15; i++) begin
      apply(15'(1 << (i - 1)) << 0 == 0 ? '0 : '0, '0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
      apply(ext_from(i), '0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
      chk("R4 pri0", 1'b1, 9'h040 | 9'(i));
    end
    // R4: priority 15 masks every level
    apply('1, '1, 4'd15, 1'b1, 3'd0, 9'h0, 1'b0);
    chk("R4 pri15", 1'b0, 9'h000);
    // R2: timer match bits fold into level 14
    apply('0, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk("R2 tick", 1'b1, 9'h04E);
    apply('0, '0, 4'd15, 1'b1, 3'd0, 9'h0, 1'b0);
    apply('0, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk("R2 stick", 1'b1, 9'h04E);
    // R1: software level bit, timer bits do not count as levels 0/16
    apply('0, 17'h00020, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk("R1 sw5", 1'b1, 9'h045);
    apply('0, 17'h00001, 4'd13, 1'b1, 3'd0, 9'h0, 1'b0);
    chk("R1 tick14", 1'b1, 9'h04E);
    // R3: vector busy freezes outputs
    apply(ext_from(15), '0, 4'd0, 1'b0, 3'd0, 9'h0, 1'b1);
    chk("R3 hold", 1'b1, 9'h04E);
    // R7: enable off clears
    apply(ext_from(15), '0, 4'd0, 1'b0, 3'd0, 9'h0, 1'b0);
    chk("R7 ie0", 1'b0, 9'h000);
    // R6: nested external trap of higher code blocks
    apply(ext_from(3), '0, 4'd0, 1'b1, 3'd1, 9'h047, 1'b0);
    chk("R6 block", 1'b0, 9'h000);
    apply(ext_from(3), '0, 4'd0, 1'b1, 3'd1, 9'h027, 1'b0);
    chk("R6 non-ext", 1'b1, 9'h043);
    apply(ext_from(3), '0, 4'd0, 1'b0, 3'd0, 9'h0, 1'b0);
    apply(ext_from(3), '0, 4'd0, 1'b1, 3'd0, 9'h047, 1'b0);
    chk("R6 tl0", 1'b1, 9'h043);
    // R4: strictly above priority
    apply(ext_from(5), '0, 4'd5, 1'b1, 3'd0, 9'h0, 1'b0);
    chk("R4 equal", 1'b0, 9'h000);
    apply(ext_from(6), '0, 4'd5, 1'b1, 3'd0, 9'h0, 1'b0);
    chk("R4 above", 1'b1, 9'h046);
    // R5: highest wins
    apply(ext_from(3) | ext_from(9) | ext_from(12), '0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0);
    chk("R5 highest", 1'b1, 9'h04C);

    // Random phase against the model
    for (int k = 0; k < 4000; k++) begin
      logic [15:1] e;
      logic [16:0] s;
      logic [8:0] a;
      e = ($urandom % 3 == 0) ? 15'($urandom) : 15'($urandom) & 15'($urandom) & 15'($urandom);
      s = ($urandom % 2 == 0) ? '0 : 17'($urandom) & 17'($urandom);
      a = ($urandom % 2 == 0) ? (9'h040 | 9'($urandom % 16)) : 9'($urandom);
      apply(e, s, 4'($urandom), ($urandom % 8) != 0, 3'($urandom % 4), a,
            ($urandom % 8) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  function automatic logic [15:1] ext_from(int lv);
    logic [15:1] r;
    r = '0;
    r[lv] = 1'b1;
    return r;
  endfunction
endmodule